// File: doc/BRIEF.md
# External Line Edge-Trigger Controller

This block watches a set of asynchronous external lines and turns selected transitions on them into interrupt requests and event pulses. Each line is brought into the clock domain through a synchroniser. A transition is then found by comparing the synchronised level with its value one cycle earlier. Software decides, line by line, whether a rising transition, a falling transition, or both count as a trigger. The same choice applies to the interrupt path and to the event path.

A trigger on a line sets that line's pending flag when the line's interrupt mask bit is on. The line's interrupt request stays high while the flag is set and the mask bit is on. Software clears the flag by writing a 1 to it. A trigger on a line whose event mask bit is on gives a single-cycle event pulse, whether or not the interrupt path takes it. Software reaches all of this through a small 32-bit register interface. It has a one-cycle write strobe and a one-cycle read strobe, and the read data is registered.

A transition that is detected in the same cycle as a write to its own trigger-select register is lost. This keeps a trigger from firing on a select value that is only half updated.

Top module: `line_trig_ctrl`

## Requirements
- R1: After reset, every register reads 0, and `irq_out` and `evt_out` are all 0.
- R2: The registers sit at these byte offsets. Interrupt mask is at 0x00, event mask at 0x04, rising select at 0x08, falling select at 0x0C and pending at 0x14. Bit n of each register belongs to line n. A read strobe loads `bus_rdata` at the next clock edge, and `bus_rdata` holds that value until the next read. A read of any other offset returns 0.
- R3: Bits 31:19 of every register read as 0, and writes to those bits are ignored.
- R4: Rising select bit n = 1 makes a 0→1 transition of line n a trigger, and falling select bit n = 1 makes a 1→0 transition a trigger. When a select bit is 0, that transition is no trigger for either path.
- R5: When both select bits of a line are 1, a transition in either direction is a trigger.
- R6: A rising transition detected in the same cycle as a write to offset 0x08 is dropped. It sets no pending bit and gives no event pulse. A falling transition is dropped in the same way during a write to 0x0C. A write to the other select register does not drop a transition.
- R7: A trigger sets pending bit n only when interrupt mask bit n is 1. `irq_out[n]` is pending bit n AND interrupt mask bit n.
- R8: Writing 1 to pending bit n clears it, and writing 0 leaves it unchanged. If a trigger and a clear of the same bit happen in the same cycle, the bit ends up set.
- R9: A trigger with event mask bit n = 1 gives `evt_out[n]` = 1 for exactly one cycle. This does not depend on the interrupt mask.
- R10: Latency. Suppose a new line level is first sampled at clock edge k. Then the trigger appears on `evt_out` and in the pending register right after edge k+2, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| lines_in | input | 19 | Asynchronous external lines |
| irq_out | output | 19 | Per-line interrupt request |
| evt_out | output | 19 | Per-line one-cycle event pulse |

## Verification
Directed patterns drive single rising and falling transitions on lines with only one select bit set. These separate the two edge polarities, the both-edges case and the two-edge latency. Further directed patterns place a select-register write, or a pending clear, in exactly the cycle a transition is detected. These show whether the drop rule is tied to the matching register only, and whether set beats clear. A long run then mixes random line toggles with random writes and reads, including unmapped offsets and reserved bits. A cycle model in the bench checks every interrupt, event and read-data value, which catches masking and mux errors that the directed cases do not reach.

// File: rtl/line_trig_pkg.sv
package line_trig_pkg;

    localparam int LINES_DEF  = 19;
    localparam int DATA_W_DEF = 32;
    localparam int ADDR_W_DEF = 8;

    localparam logic [31:0] OFF_IMASK = 32'h00;
    localparam logic [31:0] OFF_EMASK = 32'h04;
    localparam logic [31:0] OFF_RSEL  = 32'h08;
    localparam logic [31:0] OFF_FSEL  = 32'h0C;
    localparam logic [31:0] OFF_PEND  = 32'h14;

    typedef enum logic [2:0] {
        SEL_IMASK,
        SEL_EMASK,
        SEL_RSEL,
        SEL_FSEL,
        SEL_PEND,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_offset(input logic [31:0] off);
        case (off)
            OFF_IMASK: return SEL_IMASK;
            OFF_EMASK: return SEL_EMASK;
            OFF_RSEL:  return SEL_RSEL;
            OFF_FSEL:  return SEL_FSEL;
            OFF_PEND:  return SEL_PEND;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/line_sync_edge.sv
module line_sync_edge #(
    parameter int NUM_LINES   = 19,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] lines_in,
    output logic [NUM_LINES-1:0] rise_vec,
    output logic [NUM_LINES-1:0] fall_vec
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [NUM_LINES-1:0] stage_q [SYNC_STAGES];
    logic [NUM_LINES-1:0] prev_q;

    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= lines_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= stage_q[LAST];
    end

    always_comb begin
        rise_vec = stage_q[LAST] & ~prev_q;
        fall_vec = ~stage_q[LAST] & prev_q;
    end

endmodule

// File: rtl/trig_regs.sv
module trig_regs
    import line_trig_pkg::*;
#(
    parameter int NUM_LINES = 19,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic [NUM_LINES-1:0] pend,
    output logic [NUM_LINES-1:0] imask,
    output logic [NUM_LINES-1:0] emask,
    output logic [NUM_LINES-1:0] rsel,
    output logic [NUM_LINES-1:0] fsel,
    output logic                 wr_rsel,
    output logic                 wr_fsel,
    output logic [NUM_LINES-1:0] clr_mask,
    output logic [DATA_W-1:0]    bus_rdata
);
    reg_sel_e             sel;
    logic [NUM_LINES-1:0] wfield;
    logic [DATA_W-1:0]    rd_mux;
    logic                 unused_hi;

    assign sel       = decode_offset(32'(bus_addr));
    assign wfield    = bus_wdata[NUM_LINES-1:0];
    assign unused_hi = ^bus_wdata[DATA_W-1:NUM_LINES];

    assign wr_rsel  = bus_wr && (sel == SEL_RSEL);
    assign wr_fsel  = bus_wr && (sel == SEL_FSEL);
    assign clr_mask = (bus_wr && (sel == SEL_PEND)) ? wfield : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            imask <= '0;
            emask <= '0;
            rsel  <= '0;
            fsel  <= '0;
        end else if (bus_wr) begin
            case (sel)
                SEL_IMASK: imask <= wfield;
                SEL_EMASK: emask <= wfield;
                SEL_RSEL:  rsel  <= wfield;
                SEL_FSEL:  fsel  <= wfield;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_IMASK: rd_mux = DATA_W'(imask);
            SEL_EMASK: rd_mux = DATA_W'(emask);
            SEL_RSEL:  rd_mux = DATA_W'(rsel);
            SEL_FSEL:  rd_mux = DATA_W'(fsel);
            SEL_PEND:  rd_mux = DATA_W'(pend);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/trig_pend.sv
module trig_pend #(
    parameter int NUM_LINES = 19
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] rise_vec,
    input  logic [NUM_LINES-1:0] fall_vec,
    input  logic [NUM_LINES-1:0] rsel,
    input  logic [NUM_LINES-1:0] fsel,
    input  logic [NUM_LINES-1:0] imask,
    input  logic [NUM_LINES-1:0] emask,
    input  logic                 wr_rsel,
    input  logic                 wr_fsel,
    input  logic [NUM_LINES-1:0] clr_mask,
    output logic [NUM_LINES-1:0] pend,
    output logic [NUM_LINES-1:0] irq_out,
    output logic [NUM_LINES-1:0] evt_out
);
    logic [NUM_LINES-1:0] rise_ok;
    logic [NUM_LINES-1:0] fall_ok;
    logic [NUM_LINES-1:0] trig;

    assign rise_ok = wr_rsel ? '0 : (rise_vec & rsel);
    assign fall_ok = wr_fsel ? '0 : (fall_vec & fsel);
    assign trig    = rise_ok | fall_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= '0;
            evt_out <= '0;
        end else begin
            pend    <= (pend & ~clr_mask) | (trig & imask);
            evt_out <= trig & emask;
        end
    end

    assign irq_out = pend & imask;

endmodule

// File: rtl/line_trig_ctrl.sv
module line_trig_ctrl
    import line_trig_pkg::*;
#(
    parameter int NUM_LINES   = LINES_DEF,
    parameter int DATA_W      = DATA_W_DEF,
    parameter int ADDR_W      = ADDR_W_DEF,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_LINES-1:0] lines_in,
    output logic [NUM_LINES-1:0] irq_out,
    output logic [NUM_LINES-1:0] evt_out
);
    logic [NUM_LINES-1:0] rise_vec, fall_vec;
    logic [NUM_LINES-1:0] imask, emask, rsel, fsel, pend, clr_mask;
    logic                 wr_rsel, wr_fsel;

    line_sync_edge #(
        .NUM_LINES  (NUM_LINES),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .lines_in(lines_in),
        .rise_vec(rise_vec),
        .fall_vec(fall_vec)
    );

    trig_regs #(
        .NUM_LINES(NUM_LINES),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .pend     (pend),
        .imask    (imask),
        .emask    (emask),
        .rsel     (rsel),
        .fsel     (fsel),
        .wr_rsel  (wr_rsel),
        .wr_fsel  (wr_fsel),
        .clr_mask (clr_mask),
        .bus_rdata(bus_rdata)
    );

    trig_pend #(
        .NUM_LINES(NUM_LINES)
    ) u_pend (
        .clk     (clk),
        .rst     (rst),
        .rise_vec(rise_vec),
        .fall_vec(fall_vec),
        .rsel    (rsel),
        .fsel    (fsel),
        .imask   (imask),
        .emask   (emask),
        .wr_rsel (wr_rsel),
        .wr_fsel (wr_fsel),
        .clr_mask(clr_mask),
        .pend    (pend),
        .irq_out (irq_out),
        .evt_out (evt_out)
    );

endmodule

// File: rtl/line_trig_chk.sv
module line_trig_chk
    import line_trig_pkg::*;
#(
    parameter int NUM_LINES = 19,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic [NUM_LINES-1:0] evt_out,
    input logic [NUM_LINES-1:0] pend,
    input logic [NUM_LINES-1:0] imask,
    input logic [NUM_LINES-1:0] rise_vec,
    input logic [NUM_LINES-1:0] fall_vec
);
    reg_sel_e sel;
    assign sel = decode_offset(32'(bus_addr));

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DATA_W-1:NUM_LINES] == '0); // R3

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel == SEL_NONE) |=> bus_rdata == '0); // R2

    AST_NEW_PEND_MASKED: assert property (@(posedge clk) disable iff (rst)
        ((pend & ~$past(pend)) & ~$past(imask)) == '0); // R7

    AST_RISE_DROP: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SEL_RSEL) |=> (evt_out & $past(rise_vec)) == '0); // R6

    AST_FALL_DROP: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SEL_FSEL) |=> (evt_out & $past(fall_vec)) == '0); // R6

    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SEL_PEND) |=>
            (pend & $past(bus_wdata[NUM_LINES-1:0]) & ~$past(rise_vec | fall_vec)) == '0); // R8

endmodule

bind line_trig_ctrl line_trig_chk #(
    .NUM_LINES(NUM_LINES),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .evt_out  (evt_out),
    .pend     (pend),
    .imask    (imask),
    .rise_vec (rise_vec),
    .fall_vec (fall_vec)
);

// File: tb/test_line_trig_ctrl.sv
`timescale 1ns/1ps
module test_line_trig_ctrl;
    localparam int N = 19;
    localparam logic [N-1:0] ALL = '1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        b_wr = 1'b0, b_rd = 1'b0;
    logic [7:0]  b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic [31:0] b_rdata;
    logic [N-1:0] lines = '0;
    logic [N-1:0] irq, evt;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    line_trig_ctrl i_line_trig_ctrl (
        .clk(clk), .rst(rst), .bus_wr(b_wr), .bus_rd(b_rd), .bus_addr(b_addr),
        .bus_wdata(b_wdata), .bus_rdata(b_rdata), .lines_in(lines),
        .irq_out(irq), .evt_out(evt)
    );

    // Cycle model built from the requirements
    logic [N-1:0] m_s1, m_s2, m_p, m_im, m_em, m_rs, m_fs, m_pend, m_evt;
    logic [31:0]  m_rdata;

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00: return 32'(m_im);
            8'h04: return 32'(m_em);
            8'h08: return 32'(m_rs);
            8'h0C: return 32'(m_fs);
            8'h14: return 32'(m_pend);
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [N-1:0] rise, fall, trig, clr, wf;
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_p = '0; m_im = '0; m_em = '0;
            m_rs = '0; m_fs = '0; m_pend = '0; m_evt = '0; m_rdata = '0;
        end else begin
            rise = m_s2 & ~m_p;
            fall = ~m_s2 & m_p;
            trig = ((b_wr && b_addr == 8'h08) ? '0 : (rise & m_rs))
                 | ((b_wr && b_addr == 8'h0C) ? '0 : (fall & m_fs));
            wf   = b_wdata[N-1:0];
            clr  = (b_wr && b_addr == 8'h14) ? wf : '0;
            if (b_rd) m_rdata = model_read(b_addr);
            m_evt  = trig & m_em;
            m_pend = (m_pend & ~clr) | (trig & m_im);
            if (b_wr) begin
                case (b_addr)
                    8'h00: m_im = wf;
                    8'h04: m_em = wf;
                    8'h08: m_rs = wf;
                    8'h0C: m_fs = wf;
                    default: ;
                endcase
            end
            m_p = m_s2; m_s2 = m_s1; m_s1 = lines;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Continuous comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R7 irq vs model", 32'(irq), 32'(m_pend & m_im));
            chk("R9 evt vs model", 32'(evt), 32'(m_evt));
            chk("R2 rdata vs model", b_rdata, m_rdata);
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        b_wr = 1'b1; b_addr = a; b_wdata = d;
        @(negedge clk);
        b_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        b_rd = 1'b1; b_addr = a;
        @(negedge clk);
        b_rd = 1'b0;
        d = b_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'h00C0FFEE));
        idle(4);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        chk("R1 irq after reset", 32'(irq), 32'h0);
        chk("R1 evt after reset", 32'(evt), 32'h0);
        foreach (OFFS[i]) begin
            bus_read(OFFS[i], rd);
            chk("R1 register reset value", rd, 32'h0);
        end

        // R3 reserved bits
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_read(8'h08, rd);
        chk("R3 reserved bits read 0", rd, 32'h0007_FFFF);
        bus_write(8'h08, 32'h0);

        // R2 map and unmapped offsets
        bus_write(8'h04, 32'h0005_A5A5);
        bus_read(8'h04, rd);
        chk("R2 event mask readback", rd, 32'h0005_A5A5);
        bus_read(8'h10, rd);
        chk("R2 unmapped 0x10", rd, 32'h0);
        bus_read(8'h18, rd);
        chk("R2 unmapped 0x18", rd, 32'h0);
        idle(1);
        chk("R2 rdata holds without read", b_rdata, 32'h0);

        // Setup: interrupt mask all but line 5, event mask all
        bus_write(8'h00, 32'(ALL & ~(N'(1) << 5)));
        bus_write(8'h04, 32'(ALL));
        bus_write(8'h08, 32'h0000_0001);

        // R10 latency and R4 rising edge on line 0
        lines[0] = 1'b1;
        idle(2);
        chk("R10 no event before edge k+2", 32'(evt), 32'h0);
        idle(1);
        chk("R10 R4 event after edge k+2", 32'(evt), 32'h1);
        idle(1);
        chk("R9 event lasts one cycle", 32'(evt), 32'h0);
        lines[0] = 1'b0;          // falling, not selected
        idle(4);
        bus_read(8'h14, rd);
        chk("R4 only rising set pending", rd, 32'h1);
        chk("R7 irq follows pending", 32'(irq), 32'h1);
        bus_write(8'h14, 32'h1);
        bus_read(8'h14, rd);
        chk("R8 write 1 clears", rd, 32'h0);

        // R8 writing 0 has no effect
        bus_write(8'h08, 32'h0000_0002);
        lines[1] = 1'b1;
        idle(4);
        bus_write(8'h14, 32'h0);
        bus_read(8'h14, rd);
        chk("R8 write 0 keeps pending", rd, 32'h2);
        bus_write(8'h14, 32'(ALL));

        // R4 falling only on line 1
        bus_write(8'h08, 32'h0);
        bus_write(8'h0C, 32'h0000_0002);
        lines[1] = 1'b0;
        idle(4);
        bus_read(8'h14, rd);
        chk("R4 falling edge sets pending", rd, 32'h2);
        bus_write(8'h14, 32'(ALL));

        // R5 both edges on line 2
        bus_write(8'h08, 32'h0000_0004);
        bus_write(8'h0C, 32'h0000_0004);
        lines[2] = 1'b1;
        idle(4);
        bus_read(8'h14, rd);
        chk("R5 rising with both selects", rd, 32'h4);
        bus_write(8'h14, 32'(ALL));
        lines[2] = 1'b0;
        idle(4);
        bus_read(8'h14, rd);
        chk("R5 falling with both selects", rd, 32'h4);
        bus_write(8'h14, 32'(ALL));

        // R6 rising edge dropped by write to rising select
        bus_write(8'h08, 32'h0000_0008);
        bus_write(8'h0C, 32'h0000_0008);
        lines[3] = 1'b1;
        idle(2);
        bus_write(8'h08, 32'h0000_0008);
        chk("R6 dropped edge gives no event", 32'(evt), 32'h0);
        idle(2);
        bus_read(8'h14, rd);
        chk("R6 rising edge dropped", rd, 32'h0);
        // falling edge during a rising-select write still counts
        lines[3] = 1'b0;
        idle(2);
        bus_write(8'h08, 32'h0000_0008);
        chk("R6 other register write keeps event", 32'(evt), 32'h8);
        idle(2);
        bus_read(8'h14, rd);
        chk("R6 falling edge kept", rd, 32'h8);
        bus_write(8'h14, 32'(ALL));
        // falling edge dropped by write to falling select
        lines[3] = 1'b1;
        idle(4);
        bus_write(8'h14, 32'(ALL));
        lines[3] = 1'b0;
        idle(2);
        bus_write(8'h0C, 32'h0000_0008);
        idle(2);
        bus_read(8'h14, rd);
        chk("R6 falling edge dropped", rd, 32'h0);

        // R8 set wins over clear
        bus_write(8'h08, 32'h0000_0010);
        bus_write(8'h0C, 32'h0);
        lines[4] = 1'b1;
        idle(4);
        lines[4] = 1'b0;
        idle(4);
        lines[4] = 1'b1;
        idle(2);
        bus_write(8'h14, 32'h0000_0010);
        idle(1);
        bus_read(8'h14, rd);
        chk("R8 set wins over clear", rd, 32'h10);
        bus_write(8'h14, 32'(ALL));

        // R7 and R9 on line 5 with interrupt mask off
        bus_write(8'h08, 32'h0000_0020);
        lines[5] = 1'b1;
        idle(3);
        chk("R9 event without interrupt mask", 32'(evt), 32'h20);
        idle(2);
        bus_read(8'h14, rd);
        chk("R7 masked line sets no pending", rd, 32'h0);
        chk("R7 masked line no irq", 32'(irq), 32'h0);

        // Random phase against the model
        for (int it = 0; it < 4000; it++) begin
            int r;
            r = int'($urandom % 16);
            if ($urandom % 3 == 0) lines[$urandom % N] ^= 1'b1;
            if (r == 0) begin
                bus_write(OFFS[$urandom % 6], $urandom);
            end else if (r == 1) begin
                bus_read(OFFS[$urandom % 6], rd);
            end else begin
                idle(1);
            end
        end
        idle(4);

        done = 1;
        summary();
        $finish;
    end

    localparam logic [7:0] OFFS [6] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h14, 8'h10};

endmodule